// File: doc/BRIEF.md
# Dual-Reload Alternating PWM Timer

This block is a down-counting timer that turns two reload values into a pulse-width waveform. Software sets a low/high pair of period values and raises the enable bit. The counter then counts down on each count-clock strobe. Each time it underflows, it reloads from the other value and the output flip-flop inverts. The two phases of the waveform therefore last `reload0 + 1` and `reload1 + 1` strobes.

Two run modes exist. In continuous mode the waveform repeats until the enable bit is cleared. The output also inverts at the moment counting starts, and a one-clock request pulse for an interrupt or DMA channel marks every second underflow. In single-shot mode the output produces exactly one phase pair, with no inversion at start. The request fires on the second underflow only, and the timer then halts by itself.

The prescaler that produces the count strobe and the register decoding for software access both live outside this block.

Top module: `pwm_dual_reload_timer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `wave_out`, `running` and `req_pulse` are all 0.
- R2: A rising edge of `enable` starts a run: the counter takes `reload0`, `running` is 1 from the next cycle on, and the run mode (`mode_oneshot` = 0 continuous, 1 single-shot) is captured at that edge; later changes of `mode_oneshot` do not affect the run.
- R3: An underflow is a count strobe that arrives while the counter holds zero. Phase lengths follow `reload0 + 1`, `reload1 + 1`, `reload0 + 1`, ... strobes, alternating on each underflow.
- R4: In continuous mode `wave_out` inverts in the cycle after the start edge and in the cycle after every underflow.
- R5: In single-shot mode `wave_out` does not invert at start. It inverts after each of the two underflows, and `running` is 0 from the cycle after the second underflow. Further strobes then change nothing while `enable` stays high.
- R6: `req_pulse` is high for exactly one clock after the 2nd, 4th, 6th ... underflow of a continuous run, and after only the 2nd underflow of a single-shot run.
- R7: With `enable` at 0, `running` is 0 from the next cycle. `wave_out` keeps its level, and no request is raised, whatever `cnt_tick` does.
- R8: Cycles with `cnt_tick` at 0 neither advance the counter nor change `wave_out` or `req_pulse`.
- R9: A new run always starts from `reload0` with the underflow parity cleared, so its first request follows its own second underflow even if the previous run stopped after an odd count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_tick | input | 1 | Count-clock strobe, one clock wide |
| enable | input | 1 | Run enable; its rising edge starts a run |
| mode_oneshot | input | 1 | 0 continuous, 1 single-shot |
| reload0 | input | 16 | First-phase reload value |
| reload1 | input | 16 | Second-phase reload value |
| wave_out | output | 1 | Waveform flip-flop |
| running | output | 1 | Counter active |
| req_pulse | output | 1 | Interrupt/DMA request, one clock wide |

## Verification
The assertions take for granted that `cnt_tick` is a single-clock strobe and that `reload0`/`reload1` stay stable during a run. They also take for granted that a new run begins only after `enable` has been low for at least one clock. The stimulus changes reload values and mode only while `enable` is low, drives every input at the falling clock edge, and always drops `enable` for several cycles between runs. The single exception is `mode_oneshot`, which is flipped deliberately during continuous runs to show that the mode captured at the start is the one that applies.

// File: rtl/pwmt_pkg.sv
`timescale 1ns/1ps
package pwmt_pkg;

  typedef enum logic {
    RUN_CONT    = 1'b0,
    RUN_ONESHOT = 1'b1
  } run_mode_e;

  // Output inverts at start only for the repeating waveform.
  function automatic logic invert_at_start(input run_mode_e m);
    return (m == RUN_CONT);
  endfunction

  // The second phase of a pair ends on an even underflow; that is when a
  // request is raised in both modes (single-shot never reaches a 4th).
  function automatic logic request_on_underflow(input logic phase_sel);
    return phase_sel;
  endfunction

  // A single-shot run ends with the underflow that closes phase 1.
  function automatic logic run_completes(input run_mode_e m, input logic phase_sel);
    return (m == RUN_ONESHOT) && phase_sel;
  endfunction

endpackage

// File: rtl/tmr_downcount.sv
`timescale 1ns/1ps
module tmr_downcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             at_zero
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= step_down(cnt);
  end

  assign at_zero = (cnt == '0);

  // R3: each counted strobe lowers the value by exactly one
  p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |=> (cnt == $past(cnt) - ONE));

  // R8: without load or strobe the count is frozen
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && !dec) |=> $stable(cnt));

  // R2: a load always lands the presented value
  p_load_value_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/tmr_sequencer.sv
`timescale 1ns/1ps
module tmr_sequencer
  import pwmt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  logic      mode_in,
  input  logic      cnt_tick,
  input  logic      at_zero,
  output logic      start_evt,
  output logic      uf_evt,
  output logic      done_evt,
  output logic      dec,
  output logic      running,
  output logic      phase,
  output run_mode_e mode_q
);

  logic en_q;
  logic run_tick;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= enable;
  end

  assign start_evt = enable && !en_q;
  assign run_tick  = running && enable && cnt_tick;
  assign uf_evt    = run_tick && at_zero;
  assign dec       = run_tick && !at_zero;
  assign done_evt  = uf_evt && run_completes(mode_q, phase);

  always_ff @(posedge clk) begin
    if (rst)            running <= 1'b0;
    else if (!enable)   running <= 1'b0;
    else if (start_evt) running <= 1'b1;
    else if (done_evt)  running <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)            phase <= 1'b0;
    else if (start_evt) phase <= 1'b0;
    else if (uf_evt)    phase <= !phase;
  end

  always_ff @(posedge clk) begin
    if (rst)            mode_q <= RUN_CONT;
    else if (start_evt) mode_q <= run_mode_e'(mode_in);
  end

  // R7: dropping enable halts the run on the next edge
  p_disable_stops_r7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !running);

  // R5: single-shot run ends right after its second underflow
  p_single_done_r5: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> !running);

  // R3: every underflow swaps the active reload
  p_phase_swap_r3: assert property (@(posedge clk) disable iff (rst)
    uf_evt |=> (phase != $past(phase)));

  // R9: a new run begins in phase 0 and running
  p_fresh_start_r9: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (running && !phase));

endmodule

// File: rtl/tmr_flop_out.sv
`timescale 1ns/1ps
module tmr_flop_out
  import pwmt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_evt,
  input  run_mode_e start_mode,
  input  logic      uf_evt,
  input  logic      uf_phase,
  output logic      wave,
  output logic      req
);

  logic flip;

  assign flip = (start_evt && invert_at_start(start_mode)) || uf_evt;

  always_ff @(posedge clk) begin
    if (rst)       wave <= 1'b0;
    else if (flip) wave <= !wave;
  end

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= uf_evt && request_on_underflow(uf_phase);
  end

  // R6: the request never lasts more than one clock
  p_req_one_clock_r6: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);

  // R6: a request is always preceded by an underflow in phase 1
  p_req_source_r6: assert property (@(posedge clk) disable iff (rst)
    req |-> $past(uf_evt && uf_phase));

endmodule

// File: rtl/pwm_dual_reload_timer.sv
`timescale 1ns/1ps
module pwm_dual_reload_timer
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_tick,
  input  logic             enable,
  input  logic             mode_oneshot,
  input  logic [CNT_W-1:0] reload0,
  input  logic [CNT_W-1:0] reload1,
  output logic             wave_out,
  output logic             running,
  output logic             req_pulse
);

  logic             start_evt;
  logic             uf_evt;
  logic             done_evt;
  logic             dec;
  logic             phase;
  run_mode_e        mode_q;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             at_zero;

  // Value to load: reload0 at start; else the reload of the phase entered.
  function automatic logic [CNT_W-1:0] pick_reload(
    input logic             starting,
    input logic             cur_phase,
    input logic [CNT_W-1:0] r0,
    input logic [CNT_W-1:0] r1
  );
    if (starting || cur_phase) return r0;
    return r1;
  endfunction

  assign load     = start_evt || uf_evt;
  assign load_val = pick_reload(start_evt, phase, reload0, reload1);

  tmr_sequencer u_seq (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .mode_in   (mode_oneshot),
    .cnt_tick  (cnt_tick),
    .at_zero   (at_zero),
    .start_evt (start_evt),
    .uf_evt    (uf_evt),
    .done_evt  (done_evt),
    .dec       (dec),
    .running   (running),
    .phase     (phase),
    .mode_q    (mode_q)
  );

  tmr_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .dec      (dec),
    .cnt      (cnt),
    .at_zero  (at_zero)
  );

  tmr_flop_out u_out (
    .clk        (clk),
    .rst        (rst),
    .start_evt  (start_evt),
    .start_mode (run_mode_e'(mode_oneshot)),
    .uf_evt     (uf_evt),
    .uf_phase   (phase),
    .wave       (wave_out),
    .req        (req_pulse)
  );

  // R7: with enable low the waveform holds its level
  p_wave_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(wave_out));

  // R8: no strobe, no underflow, no waveform change while running
  p_no_tick_no_flip_r8: assert property (@(posedge clk) disable iff (rst)
    (!cnt_tick && !start_evt) |=> $stable(wave_out));

  // R2: a run entered from idle begins with reload0
  p_start_loads_r0_r2: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (cnt == $past(reload0)));

  // R5: a finished single-shot leaves the output flop alone
  p_single_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!running && !start_evt) |=> $stable(wave_out));

  // R6: request only on an underflow closing phase 1
  p_req_after_uf_r6: assert property (@(posedge clk) disable iff (rst)
    (uf_evt && !phase) |=> !req_pulse);

endmodule

// File: tb/sim_pwm_dual_reload_timer.sv
`timescale 1ns/1ps
module sim_pwm_dual_reload_timer;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         cnt_tick;
  logic         enable;
  logic         mode_oneshot;
  logic [W-1:0] reload0;
  logic [W-1:0] reload1;
  wire          wave_out;
  wire          running;
  wire          req_pulse;

  int   n_chk  = 0;
  int   n_fail = 0;
  int   cyc    = 0;
  logic exp_wave = 1'b0;

  always #10 clk = ~clk;

  pwm_dual_reload_timer #(.CNT_W(W)) u0 (
    .clk          (clk),
    .rst          (rst),
    .cnt_tick     (cnt_tick),
    .enable       (enable),
    .mode_oneshot (mode_oneshot),
    .reload0      (reload0),
    .reload1      (reload1),
    .wave_out     (wave_out),
    .running      (running),
    .req_pulse    (req_pulse)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual cycles %0d, expected fewer than %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // Drive at a falling edge, then wait one full clock to the next falling edge.
  task automatic cycle(input logic tick);
    cnt_tick = tick;
    @(negedge clk);
  endtask

  // Returns k if tick number n (1-based) is the k-th underflow, else 0.
  function automatic int uf_index(input int n, input int l0, input int l1);
    int t = 0;
    for (int k = 1; k < 64; k++) begin
      t += (k % 2 == 1) ? l0 : l1;
      if (t == n) return k;
      if (t > n)  return 0;
    end
    return 0;
  endfunction

  task automatic run_case(input int r0, input int r1, input logic os, input int gap);
    int l0 = r0 + 1;
    int l1 = r1 + 1;
    int total;
    reload0      = W'(r0);
    reload1      = W'(r1);
    mode_oneshot = os;
    enable       = 1'b1;
    cycle(1'b0);
    chk("R2 running after start", running, 1);
    if (!os) exp_wave = ~exp_wave;
    chk(os ? "R5 no flip at start" : "R4 flip at start", wave_out, exp_wave);
    chk("R6 no request at start", req_pulse, 0);
    if (!os) mode_oneshot = 1'b1;   // R2: must not turn the run into a single-shot
    total = os ? (l0 + l1 + 3) : (2 * l0 + l1 + 1);
    for (int n = 1; n <= total; n++) begin
      int   k;
      logic exp_req;
      logic exp_run;
      repeat (gap) begin
        cycle(1'b0);
        chk("R8 idle cycle request", req_pulse, 0);
        chk("R8 idle cycle wave", wave_out, exp_wave);
      end
      cycle(1'b1);
      k = uf_index(n, l0, l1);
      if (os && k > 2) k = 0;
      if (k != 0) exp_wave = ~exp_wave;
      exp_req = os ? (k == 2) : (k != 0 && k % 2 == 0);
      exp_run = os ? (n < l0 + l1) : 1'b1;
      chk(os ? "R5 wave" : "R3 R4 wave", wave_out, exp_wave);
      chk("R6 R9 request", req_pulse, exp_req);
      chk(os ? "R5 running" : "R2 running", running, exp_run);
    end
    enable = 1'b0;
    cycle(1'b1);
    chk("R7 stopped", running, 0);
    chk("R7 wave held", wave_out, exp_wave);
    repeat (3) begin
      cycle(1'b1);
      chk("R7 wave held", wave_out, exp_wave);
      chk("R7 no request", req_pulse, 0);
      chk("R7 stays stopped", running, 0);
    end
    cycle(1'b0);
  endtask

  initial begin
    rst          = 1'b1;
    cnt_tick     = 1'b0;
    enable       = 1'b0;
    mode_oneshot = 1'b0;
    reload0      = '0;
    reload1      = '0;
    repeat (3) @(negedge clk);
    chk("R1 wave in reset", wave_out, 0);
    chk("R1 running in reset", running, 0);
    chk("R1 request in reset", req_pulse, 0);
    rst = 1'b0;
    cycle(1'b1);
    chk("R1 wave after reset", wave_out, 0);
    chk("R1 running after reset", running, 0);
    chk("R1 request after reset", req_pulse, 0);

    for (int gap = 0; gap <= 2; gap += 2)
      for (int os = 0; os <= 1; os++)
        for (int r0 = 0; r0 <= 3; r0++)
          for (int r1 = 0; r1 <= 3; r1++)
            run_case(r0, r1, os[0], gap);

    run_case(300, 5, 1'b0, 0);
    run_case(7, 260, 1'b1, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule